// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

The block is a single 64-bit add/subtract datapath whose internal carry chain can be cut at byte boundaries. The cuts are chosen at run time by a lane-width selector. One operation therefore performs eight independent 8-bit, four 16-bit or two 32-bit operations, or one full 64-bit operation. Each lane is either added or subtracted, interpreted as signed or unsigned, and either wraps modulo its width or clamps to the nearest representable bound.

A packed result comes out together with a per-byte overflow mask that tells which lanes left their representable range. Media kernels use it for pixel and sample arithmetic where clipping is wanted instead of wrap-around. By default the outputs are registered, giving one cycle of latency. A parameter removes the register stage and makes the block purely combinational.

Top module: `simd_sat_adder`

## Requirements
- R1: `mode_i` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives one 64-bit lane. Lane k occupies bits [k*w+w-1 : k*w]. With `sub_i`=0 and no overflow, each lane of `sum_o` is the sum of the matching lanes of `a_i` and `b_i`, and no carry crosses a lane boundary.
- R2: With `sub_i`=1, each lane computes a minus b. The carry into the least significant bit of every lane is 1, and no borrow crosses a lane boundary.
- R3: With `sat_i`=1 and `signed_i`=0, a lane whose true result exceeds 2^w-1 reads all ones. A lane whose true result is below zero reads all zeros.
- R4: With `sat_i`=1 and `signed_i`=1, a lane whose true result exceeds 2^(w-1)-1 reads 0 followed by all ones. A lane whose true result is below -2^(w-1) reads 1 followed by all zeros.
- R5: With `sat_i`=0, every lane returns its true result modulo 2^w, including lanes that overflow.
- R6: `ovf_o` bit i covers bits [8i+7:8i] of the result. Every bit of a lane whose true result falls outside the range is set, and all other bits are clear. The range is [0, 2^w-1] when `signed_i`=0 and [-2^(w-1), 2^(w-1)-1] when `signed_i`=1. The mask does not depend on `sat_i`.
- R7: With OUT_REG=1, inputs presented before a rising clock edge appear on `sum_o` and `ovf_o` after that edge, and the outputs hold their previous values until then. With OUT_REG=0 the outputs follow the inputs combinationally.
- R8: With OUT_REG=1, `rst` high at a rising edge clears `sum_o` and `ovf_o` to zero. The reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | 64 | Packed first operand |
| b_i | input | 64 | Packed second operand |
| mode_i | input | 2 | Lane width select (00=8, 01=16, 10=32, 11=64 bits) |
| sub_i | input | 1 | 1 = subtract b from a, 0 = add |
| signed_i | input | 1 | 1 = lanes are two's-complement signed, 0 = unsigned |
| sat_i | input | 1 | 1 = clamp on overflow, 0 = wrap modulo lane width |
| sum_o | output | 64 | Packed lane results |
| ovf_o | output | 8 | Per-byte overflow mask, uniform across each lane |

## Verification
The bench builds the block with its defaults: NUM_BYTES=8, so the full 64-bit width, and OUT_REG=1. This lets one vector carry eight byte-lane operand pairs. Every one of the 65,536 byte operand pairs therefore passes through each of the eight combinations of add/subtract, signed/unsigned and saturate/wrap, so the 8-bit lane behaviour is swept exhaustively. The 16-, 32- and 64-bit lane widths get randomized vectors mixed with operands placed on the signed and unsigned range limits. Those vectors exercise carry isolation at each boundary position and the clamp to both bounds. Separate directed checks cover the registered latency and the reset path.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_mode_e;

    // Out-of-range request for one lane: above the maximum or below the minimum.
    typedef struct packed {
        logic above;
        logic below;
    } clamp_req_t;

    // Operation controls shared by all lanes.
    typedef struct packed {
        logic sub;
        logic is_signed;
        logic sat;
    } op_ctl_t;

    // Number of bytes in a lane, minus one, as a mask.
    function automatic int unsigned span_mask(lane_mode_e m);
        return (32'd1 << int'(m)) - 32'd1;
    endfunction

    // Byte index of the most significant byte of the lane that holds byte idx.
    function automatic int unsigned lane_msb_byte(int unsigned idx, lane_mode_e m,
                                                  int unsigned nb);
        int unsigned r;
        r = idx | span_mask(m);
        if (r > nb - 1) r = nb - 1;
        return r;
    endfunction

    function automatic logic byte_opens_lane(int unsigned idx, lane_mode_e m);
        return (idx & span_mask(m)) == 0;
    endfunction

    function automatic logic byte_closes_lane(int unsigned idx, lane_mode_e m,
                                              int unsigned nb);
        return lane_msb_byte(idx, m, nb) == idx;
    endfunction

endpackage

// File: rtl/simd_lane_ctl.sv
module simd_lane_ctl
    import simd_pkg::*;
#(
    parameter int NUM_BYTES = 8
) (
    input  lane_mode_e             mode_i,
    output logic [NUM_BYTES-1:0]   first_o,
    output logic [NUM_BYTES-1:0]   last_o
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        always_comb begin
            first_o[i] = byte_opens_lane(i, mode_i);
            last_o[i]  = byte_closes_lane(i, mode_i, NUM_BYTES);
        end
    end
endmodule

// File: rtl/simd_lane_spread.sv
module simd_lane_spread
    import simd_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int IDXW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  lane_mode_e             mode_i,
    input  logic [NUM_BYTES-1:0]   msb_flag_i,
    output logic [NUM_BYTES-1:0]   spread_o
);
    // Each byte takes the flag computed at the top byte of its own lane.
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        always_comb begin
            spread_o[i] = msb_flag_i[IDXW'(lane_msb_byte(i, mode_i, NUM_BYTES))];
        end
    end
endmodule

// File: rtl/simd_byte_add.sv
module simd_byte_add
    import simd_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              c_msb_o,
    output logic              cout_o
);
    logic [BYTE_W-1:0] bx;
    logic [BYTE_W-1:0] low;
    logic              s_msb;

    assign bx = b_i ^ {BYTE_W{sub_i}};
    // Lower bits plus carry; the top bit of low is the carry into the msb.
    assign low = {1'b0, a_i[BYTE_W-2:0]} + {1'b0, bx[BYTE_W-2:0]}
               + {{(BYTE_W-1){1'b0}}, cin_i};
    assign c_msb_o = low[BYTE_W-1];
    assign {cout_o, s_msb} = {1'b0, a_i[BYTE_W-1]} + {1'b0, bx[BYTE_W-1]}
                           + {1'b0, low[BYTE_W-1]};
    assign sum_o = {s_msb, low[BYTE_W-2:0]};
endmodule

// File: rtl/simd_byte_clamp.sv
module simd_byte_clamp
    import simd_pkg::*;
(
    input  logic [BYTE_W-1:0] raw_i,
    input  clamp_req_t        req_i,
    input  op_ctl_t           ctl_i,
    input  logic              lane_msb_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam logic [BYTE_W-1:0] ONES = '1;
    localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] SMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    always_comb begin
        byte_o = raw_i;
        if (ctl_i.sat && req_i.above) begin
            byte_o = (ctl_i.is_signed && lane_msb_i) ? SMAX : ONES;
        end else if (ctl_i.sat && req_i.below) begin
            byte_o = (ctl_i.is_signed && lane_msb_i) ? SMIN : '0;
        end
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_pkg::*;
#(
    parameter int  NUM_BYTES = 8,
    parameter bit  OUT_REG   = 1'b1,
    localparam int DW        = NUM_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DW-1:0]        a_i,
    input  logic [DW-1:0]        b_i,
    input  logic [1:0]           mode_i,
    input  logic                 sub_i,
    input  logic                 signed_i,
    input  logic                 sat_i,
    output logic [DW-1:0]        sum_o,
    output logic [NUM_BYTES-1:0] ovf_o
);
    lane_mode_e             mode;
    op_ctl_t                ctl;
    logic [NUM_BYTES-1:0]   first, last;
    logic [NUM_BYTES-1:0]   cin, cout, c_msb;
    logic [NUM_BYTES-1:0]   above_top, below_top, above_b, below_b;
    logic [DW-1:0]          raw, res_d;
    logic [NUM_BYTES-1:0]   ovf_d;

    assign mode = lane_mode_e'(mode_i);
    assign ctl  = '{sub: sub_i, is_signed: signed_i, sat: sat_i};

    simd_lane_ctl #(.NUM_BYTES(NUM_BYTES)) u_ctl (
        .mode_i (mode),
        .first_o(first),
        .last_o (last)
    );

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane_byte
        localparam int LO = i * BYTE_W;
        localparam int HI = LO + BYTE_W - 1;

        // Carry chain cut: a byte that opens a lane takes the op's carry-in.
        if (i == 0) begin : g_c0
            assign cin[i] = ctl.sub;
        end else begin : g_cn
            assign cin[i] = first[i] ? ctl.sub : cout[i-1];
        end

        simd_byte_add u_add (
            .a_i    (a_i[HI:LO]),
            .b_i    (b_i[HI:LO]),
            .sub_i  (ctl.sub),
            .cin_i  (cin[i]),
            .sum_o  (raw[HI:LO]),
            .c_msb_o(c_msb[i]),
            .cout_o (cout[i])
        );

        // Range test as if this byte were the top of its lane.
        assign above_top[i] = ctl.is_signed
                            ? ((c_msb[i] ^ cout[i]) & ~a_i[HI])
                            : (cout[i] & ~ctl.sub);
        assign below_top[i] = ctl.is_signed
                            ? ((c_msb[i] ^ cout[i]) & a_i[HI])
                            : (~cout[i] & ctl.sub);
    end

    simd_lane_spread #(.NUM_BYTES(NUM_BYTES)) u_spread_hi (
        .mode_i    (mode),
        .msb_flag_i(above_top),
        .spread_o  (above_b)
    );

    simd_lane_spread #(.NUM_BYTES(NUM_BYTES)) u_spread_lo (
        .mode_i    (mode),
        .msb_flag_i(below_top),
        .spread_o  (below_b)
    );

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_clamp
        localparam int LO = i * BYTE_W;
        localparam int HI = LO + BYTE_W - 1;
        clamp_req_t req;
        assign req = '{above: above_b[i], below: below_b[i]};

        simd_byte_clamp u_clamp (
            .raw_i     (raw[HI:LO]),
            .req_i     (req),
            .ctl_i     (ctl),
            .lane_msb_i(last[i]),
            .byte_o    (res_d[HI:LO])
        );
        assign ovf_d[i] = above_b[i] | below_b[i];
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_o <= '0;
                ovf_o <= '0;
            end else begin
                sum_o <= res_d;
                ovf_o <= ovf_d;
            end
        end
    end else begin : g_comb
        assign sum_o = res_d;
        assign ovf_o = ovf_d;
    end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk
    import simd_pkg::*;
#(
    parameter int  NUM_BYTES = 8,
    parameter bit  OUT_REG   = 1'b1,
    localparam int DW        = NUM_BYTES * BYTE_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic [DW-1:0]        a_i,
    input logic [DW-1:0]        b_i,
    input logic [1:0]           mode_i,
    input logic                 sub_i,
    input logic                 signed_i,
    input logic                 sat_i,
    input logic [DW-1:0]        sum_o,
    input logic [NUM_BYTES-1:0] ovf_o
);
    function automatic logic [DW-1:0] widen(logic [NUM_BYTES-1:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < NUM_BYTES; i++) r[i*BYTE_W +: BYTE_W] = {BYTE_W{m[i]}};
        return r;
    endfunction

    function automatic logic [DW-1:0] per_byte_sum(logic [DW-1:0] a, logic [DW-1:0] b);
        logic [DW-1:0] r;
        for (int i = 0; i < NUM_BYTES; i++)
            r[i*BYTE_W +: BYTE_W] = a[i*BYTE_W +: BYTE_W] + b[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    function automatic logic uniform_lanes(logic [NUM_BYTES-1:0] m, logic [1:0] md);
        int unsigned span;
        span = 32'd1 << md;
        for (int i = 0; i < NUM_BYTES; i++)
            if (m[i] != m[i & ~(span - 1)]) return 1'b0;
        return 1'b1;
    endfunction

    logic seen;
    always_ff @(posedge clk) seen <= 1'b1;

    if (OUT_REG) begin : g_seq
        assert_reset_clear_R8: assert property (@(posedge clk)
            (seen && $past(rst)) |-> (sum_o == '0 && ovf_o == '0));

        assert_mask_uniform_R6: assert property (@(posedge clk) disable iff (rst)
            (seen && !$past(rst)) |-> uniform_lanes(ovf_o, $past(mode_i)));

        assert_unsigned_high_clamp_R3: assert property (@(posedge clk) disable iff (rst)
            (seen && !$past(rst) && $past(sat_i && !signed_i && !sub_i))
            |-> ((sum_o & widen(ovf_o)) == widen(ovf_o)));

        assert_unsigned_low_clamp_R3: assert property (@(posedge clk) disable iff (rst)
            (seen && !$past(rst) && $past(sat_i && !signed_i && sub_i))
            |-> ((sum_o & widen(ovf_o)) == '0));

        assert_wrap_bytes_R5: assert property (@(posedge clk) disable iff (rst)
            (seen && !$past(rst) && $past(!sat_i && !sub_i && mode_i == 2'b00))
            |-> (sum_o == per_byte_sum($past(a_i), $past(b_i))));

        assert_full_width_add_R1: assert property (@(posedge clk) disable iff (rst)
            (seen && !$past(rst) && $past(!sat_i && !sub_i && mode_i == 2'b11))
            |-> (sum_o == $past(a_i) + $past(b_i)));
    end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(
    .NUM_BYTES(NUM_BYTES),
    .OUT_REG  (OUT_REG)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_i     (a_i),
    .b_i     (b_i),
    .mode_i  (mode_i),
    .sub_i   (sub_i),
    .signed_i(signed_i),
    .sat_i   (sat_i),
    .sum_o   (sum_o),
    .ovf_o   (ovf_o)
);

// File: tb/sim_simd_sat_adder.sv
`timescale 1ns/1ps
module sim_simd_sat_adder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_i = '0, b_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic        sub_i = 1'b0, signed_i = 1'b0, sat_i = 1'b0;
    logic [63:0] sum_o;
    logic [7:0]  ovf_o;

    int checks = 0;
    int errors = 0;
    bit pend = 1'b0;
    logic [63:0] exp_r;
    logic [7:0]  exp_m;
    string       exp_tag;

    always #2.5 clk = ~clk;

    simd_sat_adder u0 (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .mode_i(mode_i),
        .sub_i(sub_i), .signed_i(signed_i), .sat_i(sat_i),
        .sum_o(sum_o), .ovf_o(ovf_o)
    );

    // Arithmetic reference: true lane result in a wide signed integer.
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] md, input bit sub, input bit sgn,
                                  input bit sat, output logic [63:0] r,
                                  output logic [7:0] m, output string tag);
        int w;
        int nl;
        bit any;
        logic signed [67:0] one;
        logic signed [67:0] msk;
        w = 8 << md;
        nl = 64 / w;
        one = 68'sd1;
        msk = (one <<< w) - one;
        r = '0;
        m = '0;
        any = 1'b0;
        for (int l = 0; l < nl; l++) begin
            logic signed [67:0] va, vb, val, hi, lo, outv;
            bit ov;
            va = ($signed({4'b0, a}) >>> (l * w)) & msk;
            vb = ($signed({4'b0, b}) >>> (l * w)) & msk;
            if (sgn) begin
                if (va[w-1]) va = va - (one <<< w);
                if (vb[w-1]) vb = vb - (one <<< w);
                hi = (one <<< (w - 1)) - one;
                lo = -(one <<< (w - 1));
            end else begin
                hi = msk;
                lo = '0;
            end
            val = sub ? (va - vb) : (va + vb);
            ov = (val > hi) || (val < lo);
            outv = val;
            if (sat && val > hi) outv = hi;
            if (sat && val < lo) outv = lo;
            r = r | 64'((outv & msk) << (l * w));
            for (int k = 0; k < w / 8; k++) m[l * (w / 8) + k] = ov;
            any = any | ov;
        end
        if (any) tag = sat ? (sgn ? "R4" : "R3") : "R5";
        else     tag = sub ? "R2" : "R1";
    endfunction

    task automatic compare();
        checks++;
        if (sum_o !== exp_r) begin
            errors++;
            $display("FAIL %s mode=%0d sub=%0b sgn=%0b sat=%0b a=%h b=%h actual=%h expected=%h",
                     exp_tag, mode_i, sub_i, signed_i, sat_i, a_i, b_i, sum_o, exp_r);
        end
        checks++;
        if (ovf_o !== exp_m) begin
            errors++;
            $display("FAIL R6 mask mode=%0d actual=%b expected=%b", mode_i, ovf_o, exp_m);
        end
    endtask

    // Pipelined: each call checks the previous vector, then drives a new one.
    task automatic step(input logic [63:0] a, input logic [63:0] b, input logic [1:0] md,
                        input bit sub, input bit sgn, input bit sat);
        @(negedge clk);
        if (pend) compare();
        a_i = a; b_i = b; mode_i = md; sub_i = sub; signed_i = sgn; sat_i = sat;
        model(a, b, md, sub, sgn, sat, exp_r, exp_m, exp_tag);
        pend = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) compare();
        pend = 1'b0;
    endtask

    task automatic check_zero(input string what);
        checks++;
        if (sum_o !== '0 || ovf_o !== '0) begin
            errors++;
            $display("FAIL R8 %s actual=%h/%b expected=0/0", what, sum_o, ovf_o);
        end
    endtask

    function automatic logic [63:0] corner(int j);
        case (j % 6)
            0: return {$urandom, $urandom};
            1: return 64'h7FFF_FFFF_7FFF_FFFF;
            2: return 64'h8000_0000_8000_8000;
            3: return 64'hFFFF_FFFF_FFFF_FFFF;
            4: return 64'h0000_0001_0001_0001;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        a_i = 64'hFFFF_FFFF_FFFF_FFFF;
        b_i = 64'h0101_0101_0101_0101;
        sat_i = 1'b1;
        repeat (2) @(negedge clk);
        check_zero("initial reset");
        rst = 1'b0;

        // Exhaustive 8-bit lanes: all 65536 byte pairs, eight per vector, all op combos.
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int k = 0; k < 8192; k++) begin
                logic [63:0] va, vb;
                for (int l = 0; l < 8; l++) begin
                    va[l*8 +: 8] = 8'(k >> 5);
                    vb[l*8 +: 8] = 8'(((k & 31) << 3) | l);
                end
                step(va, vb, 2'b00, cfg[0], cfg[1], cfg[2]);
            end
        end

        // Wider lanes: random and range-limit operands.
        for (int md = 1; md < 4; md++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                for (int j = 0; j < 300; j++) begin
                    step(corner(j), corner(j + (j / 6) + md), 2'(md), cfg[0], cfg[1], cfg[2]);
                end
            end
        end
        flush();

        // R7: output holds until the clock edge, then shows the new vector.
        held = sum_o;
        step(64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 2'b11, 1'b0, 1'b0, 1'b0);
        #1;
        checks++;
        if (sum_o !== held) begin
            errors++;
            $display("FAIL R7 early update actual=%h expected=%h", sum_o, held);
        end
        flush();
        checks++;
        if (sum_o !== 64'h1234_5678_9ABC_DF00) begin
            errors++;
            $display("FAIL R7 registered result actual=%h expected=%h", sum_o,
                     64'h1234_5678_9ABC_DF00);
        end

        // R8: reset in mid-run with an overflowing vector on the inputs.
        @(negedge clk);
        rst = 1'b1;
        a_i = 64'hFFFF_FFFF_FFFF_FFFF; b_i = 64'hFFFF_FFFF_FFFF_FFFF;
        mode_i = 2'b00; sub_i = 1'b0; signed_i = 1'b0; sat_i = 1'b1;
        @(negedge clk);
        check_zero("mid-run reset");
        rst = 1'b0;

        // Directed R4 boundary: signed 16-bit lanes at both limits.
        step(64'h7FFF_8000_7FFE_8001, 64'h0001_0001_0001_0001, 2'b01, 1'b0, 1'b1, 1'b1);
        step(64'h7FFF_8000_7FFE_8001, 64'h0001_0001_0001_0001, 2'b01, 1'b1, 1'b1, 1'b1);
        flush();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule